// File: doc/BRIEF.md
# Receive Byte Buffer with Serial Read Port

This block collects demodulated receive bits into bytes and holds them in a 64-entry byte queue until a host reads them out. Bits arrive one per strobe on a plain stream input, most significant bit first. Each group of eight bits passes through a shift register and is then written into the queue as one byte. The bit input has no back-pressure, so the block never stalls the bit source. A byte that arrives while the queue is full is dropped, and a sticky overrun flag records the loss.

The host drains the queue through a serial slave read port in clock-polarity-0, clock-phase-0 form. Each frame is one byte long. A second chip-select input serves the configuration port, and it always wins over the data port. While it is low, the data port is shut off. The block reports four conditions: full, not-empty, fill level above a programmable threshold, and overrun. Any one of the four can be routed to either of two interrupt pins. The overrun-clear strobe comes from the register file. It clears the overrun flag and also empties the queue. Receiving can be turned off with the receive-enable input while the queue stays readable.

Top module: `rxbuf_top`

## Requirements
- R1: While `rx_en` is high, each cycle with `bit_valid` high shifts `bit_data` into an 8-bit register, most significant bit first. The eighth bit completes a byte, which is written into the queue. Bytes are read out in the order they were completed.
- R2: The queue holds up to 64 bytes. `st_full` is high exactly when 64 bytes are stored. `st_nempty` is high exactly when at least one byte is stored.
- R3: A byte completed while the queue is full is discarded, and `st_ovr` goes high. `st_ovr` stays high until it is cleared. The stored bytes are not changed.
- R4: A one-cycle pulse on `ovr_clr` clears `st_ovr` and empties the queue.
- R5: `st_thr` is high while the stored byte count is greater than `thr_lvl` (it rises at count `thr_lvl`+1). It falls as soon as the count drops back to `thr_lvl` or below.
- R6: A data frame starts when `cs_data_n` falls while `cs_cfg_n` is high. `miso` then presents the head byte, most significant bit first. The bit changes after each falling `sclk` edge. The head byte is removed on the eighth rising `sclk` edge. Further edges in the same frame have no effect.
- R7: A frame that starts with the queue empty shifts out 0x00 and removes nothing. The count stays at zero, with no wrap.
- R8: While `cs_cfg_n` is low, the data port is inactive: `miso` is 0, `sclk` edges remove nothing, and a data frame in progress is abandoned.
- R9: While `rx_en` is low, `bit_valid` strobes are ignored and any partial byte is discarded. Reading through the data port still works.
- R10: `irq0` and `irq1` each show the status flag chosen by their own 2-bit select: 0 = full, 1 = not-empty, 2 = threshold, 3 = overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low drops incoming bits |
| bit_valid | input | 1 | Strobe: `bit_data` carries a bit this cycle |
| bit_data | input | 1 | Demodulated bit |
| thr_lvl | input | 6 | Threshold level for `st_thr` |
| ovr_clr | input | 1 | Pulse: clear overrun and flush queue |
| irq0_sel | input | 2 | Source select for `irq0` |
| irq1_sel | input | 2 | Source select for `irq1` |
| cs_cfg_n | input | 1 | Configuration port chip select, active low, has priority |
| cs_data_n | input | 1 | Data port chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| miso | output | 1 | Serial read data |
| st_full | output | 1 | Queue holds 64 bytes |
| st_nempty | output | 1 | Queue holds at least one byte |
| st_thr | output | 1 | Fill level above `thr_lvl` |
| st_ovr | output | 1 | Sticky overrun flag |
| irq0 | output | 1 | Routed status pin 0 |
| irq1 | output | 1 | Routed status pin 1 |

## Verification
The bench fills the queue to its 64-byte limit and pushes one byte more. If the design wrapped the count or overwrote a stored byte, full would drop, or the first byte read back would be wrong. It reads from an empty queue and then checks that not-empty stays low, because a design with an underflow would wrap the count and report a phantom byte. It runs a complete data frame while the configuration select is low, and a design that ignored the priority would pop the byte that the next frame should return. It walks the threshold flag across its edge in both directions, and it checks that the overrun clear also leaves the queue empty.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef enum logic [1:0] {
    SRC_FULL   = 2'd0,
    SRC_NEMPTY = 2'd1,
    SRC_THRESH = 2'd2,
    SRC_OVR    = 2'd3
  } irq_src_e;
endpackage

// File: rtl/rxbuf_deser.sv
module rxbuf_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_en,
  input  logic         bit_valid,
  input  logic         bit_data,
  output logic         byte_valid,
  output logic [W-1:0] byte_data
);
  localparam int CW = $clog2(W);

  logic [W-1:0] sr;
  logic [CW-1:0] cnt;
  logic [W-1:0] nxt;

  assign nxt = {sr[W-2:0], bit_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      cnt        <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (!rx_en) begin
        cnt <= '0;
      end else if (bit_valid) begin
        sr <= nxt;
        if (cnt == CW'(W - 1)) begin
          cnt        <= '0;
          byte_valid <= 1'b1;
          byte_data  <= nxt;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R9: no byte can come out while receive is disabled
  p_no_byte_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !byte_valid);
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  input  logic                       flush,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       nempty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign nempty  = (count != '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & nempty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !flush |=> count == $past(count));
  p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !nempty && !push |=> count == '0);
endmodule

// File: rtl/rxbuf_spi_rd.sv
module rxbuf_spi_rd #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_cfg_n,
  input  logic         cs_data_n,
  input  logic [W-1:0] head,
  input  logic         nempty,
  output logic         miso,
  output logic         pop
);
  localparam int BW = $clog2(W) + 1;

  logic         sclk_q, act_q, loaded;
  logic [W-1:0] tx_sr;
  logic [BW-1:0] bcnt;
  logic         act, start, rise, fall;

  assign act   = ~cs_data_n & cs_cfg_n;
  assign start = act & ~act_q;
  assign rise  = act & act_q & sclk & ~sclk_q;
  assign fall  = act & act_q & ~sclk & sclk_q;
  assign pop   = rise & (bcnt == BW'(W - 1)) & loaded;
  assign miso  = act & tx_sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      act_q  <= 1'b0;
      loaded <= 1'b0;
      tx_sr  <= '0;
      bcnt   <= '0;
    end else begin
      sclk_q <= sclk;
      act_q  <= act;
      if (!act) begin
        bcnt   <= '0;
        loaded <= 1'b0;
        tx_sr  <= '0;
      end else if (start) begin
        tx_sr  <= nempty ? head : '0;
        loaded <= nempty;
        bcnt   <= '0;
      end else begin
        if (rise && bcnt < BW'(W)) bcnt <= bcnt + 1'b1;
        if (fall && bcnt != '0 && bcnt < BW'(W)) tx_sr <= {tx_sr[W-2:0], 1'b0};
      end
    end
  end

  // R8: configuration select blocks any removal
  p_cfg_blocks_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_cfg_n |-> !pop);
  // R6: at most one removal per frame
  p_one_pop_per_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !pop);
endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          bit_valid,
  input  logic          bit_data,
  input  logic [AW-1:0] thr_lvl,
  input  logic          ovr_clr,
  input  logic [1:0]    irq0_sel,
  input  logic [1:0]    irq1_sel,
  input  logic          cs_cfg_n,
  input  logic          cs_data_n,
  input  logic          sclk,
  output logic          miso,
  output logic          st_full,
  output logic          st_nempty,
  output logic          st_thr,
  output logic          st_ovr,
  output logic          irq0,
  output logic          irq1
);
  import rxbuf_pkg::*;
  localparam int CW = AW + 1;

  logic          byte_valid, pop;
  logic [W-1:0]  byte_data, head;
  logic [CW-1:0] count;
  logic [3:0]    src;
  logic [1:0]    sel_a [2];
  logic [1:0]    irq_a;

  rxbuf_deser #(.W(W)) u_deser (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .bit_valid(bit_valid), .bit_data(bit_data),
    .byte_valid(byte_valid), .byte_data(byte_data));

  rxbuf_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(byte_valid), .wdata(byte_data),
    .pop(pop), .flush(ovr_clr), .head(head), .count(count),
    .full(st_full), .nempty(st_nempty));

  rxbuf_spi_rd #(.W(W)) u_spi (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_cfg_n(cs_cfg_n),
    .cs_data_n(cs_data_n), .head(head), .nempty(st_nempty),
    .miso(miso), .pop(pop));

  assign st_thr = count > {1'b0, thr_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     st_ovr <= 1'b0;
    else if (ovr_clr)               st_ovr <= 1'b0;
    else if (byte_valid && st_full) st_ovr <= 1'b1;
  end

  assign src[SRC_FULL]   = st_full;
  assign src[SRC_NEMPTY] = st_nempty;
  assign src[SRC_THRESH] = st_thr;
  assign src[SRC_OVR]    = st_ovr;
  assign sel_a[0] = irq0_sel;
  assign sel_a[1] = irq1_sel;

  for (genvar g = 0; g < 2; g++) begin : g_irq
    assign irq_a[g] = src[sel_a[g]];
  end
  assign irq0 = irq_a[0];
  assign irq1 = irq_a[1];

  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_ovr && !ovr_clr |=> st_ovr);
  p_ovr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovr) |-> $past(st_full));
  p_clr_drops_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr |=> !st_ovr && !st_nempty);
endmodule

// File: tb/sim_rxbuf_top.sv
`timescale 1ns/1ps
module sim_rxbuf_top;
  logic clk = 0, rst_n = 0, rx_en = 0, bit_valid = 0, bit_data = 0;
  logic [5:0] thr_lvl = 6'd63;
  logic ovr_clr = 0, cs_cfg_n = 1, cs_data_n = 1, sclk = 0;
  logic [1:0] irq0_sel = 0, irq1_sel = 0;
  logic miso, st_full, st_nempty, st_thr, st_ovr, irq0, irq1;

  int n_chk = 0, n_bad = 0;
  logic [7:0] sb_q[$];

  always #2 clk = ~clk;

  rxbuf_top u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: shifts one byte in and records what the queue should hold
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); bit_valid = 1; bit_data = b[i];
      @(negedge clk); bit_valid = 0;
    end
    if (rx_en && sb_q.size() < 64) sb_q.push_back(b);
    wait_n(3);
  endtask

  // monitor: one data frame, compared with the scoreboard head
  task automatic read_cmp(input string tag);
    logic [7:0] got, exp;
    exp = (sb_q.size() != 0) ? sb_q.pop_front() : 8'h00;
    @(negedge clk); cs_data_n = 0;
    wait_n(3);
    for (int i = 7; i >= 0; i--) begin
      got[i] = miso;
      sclk = 1; wait_n(3);
      sclk = 0; wait_n(3);
    end
    cs_data_n = 1;
    wait_n(3);
    chk(tag, got, exp);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int bad;
    wait_n(4); rst_n = 1; wait_n(2);
    chk("R2 reset nempty", st_nempty, 0);
    chk("R2 reset full", st_full, 0);
    chk("R3 reset ovr", st_ovr, 0);
    rx_en = 1;

    // R1, R6: ordering and MSB-first framing
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hF0);
    chk("R2 nempty after fill", st_nempty, 1);
    read_cmp("R1/R6 byte 0"); read_cmp("R1/R6 byte 1"); read_cmp("R1/R6 byte 2");
    chk("R6 drained", st_nempty, 0);

    // R7: empty read
    read_cmp("R7 empty read value");
    chk("R7 no underflow", st_nempty, 0);
    send_byte(8'h5A);
    read_cmp("R7 read after empty");

    // R5: threshold edge both ways
    thr_lvl = 6'd3;
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    chk("R5 at level", st_thr, 0);
    send_byte(8'h44);
    chk("R5 above level", st_thr, 1);
    read_cmp("R5 read");
    chk("R5 back to level", st_thr, 0);
    read_cmp("R5 drain a"); read_cmp("R5 drain b"); read_cmp("R5 drain c");

    // R8: configuration select wins
    send_byte(8'h81);
    @(negedge clk); cs_cfg_n = 0; cs_data_n = 0;
    wait_n(3);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      if (miso !== 1'b0) bad++;
      sclk = 1; wait_n(3); sclk = 0; wait_n(3);
    end
    cs_data_n = 1; cs_cfg_n = 1; wait_n(3);
    chk("R8 miso quiet", bad, 0);
    chk("R8 nothing popped", st_nempty, 1);
    read_cmp("R8 byte kept");

    // R9: receive disabled, read in standby
    rx_en = 0;
    send_byte(8'hFF);
    chk("R9 bits ignored", st_nempty, 0);
    rx_en = 1;
    send_byte(8'h42);
    rx_en = 0;
    read_cmp("R9 read with rx off");
    rx_en = 1;

    // R2, R3: fill to capacity and overflow
    for (int k = 0; k < 64; k++) send_byte(8'(k) ^ 8'h6B);
    chk("R2 full at 64", st_full, 1);
    chk("R3 no ovr yet", st_ovr, 0);
    send_byte(8'hEE);
    chk("R3 ovr set", st_ovr, 1);
    chk("R3 still full", st_full, 1);
    // R10: routing
    irq0_sel = 2'd3; irq1_sel = 2'd0; wait_n(1);
    chk("R10 irq0 ovr", irq0, 1);
    chk("R10 irq1 full", irq1, 1);
    read_cmp("R3 oldest kept"); read_cmp("R3 second kept");
    chk("R3 full clears on read", st_full, 0);
    chk("R3 ovr sticky", st_ovr, 1);
    irq0_sel = 2'd2; irq1_sel = 2'd1; wait_n(1);
    chk("R10 irq0 thr", irq0, 1);
    chk("R10 irq1 nempty", irq1, 1);

    // R4: clear flushes
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    wait_n(1);
    sb_q.delete();
    chk("R4 ovr cleared", st_ovr, 0);
    chk("R4 flushed", st_nempty, 0);
    read_cmp("R4 read after flush");
    irq0_sel = 2'd1; wait_n(1);
    chk("R10 irq0 nempty low", irq0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule